// File: doc/BRIEF.md
# EEPROM Status and Write-Protect Unit

This unit holds the status register of a serial nonvolatile memory and makes every write-permission decision for it. It keeps a volatile write-enable latch, a busy flag, two address-range protect bits and a status-lock enable bit. It also watches an active-low hardware lock pin. Retained bits are modelled as plain registers that clear on reset. The serial shifter and the command decoder sit outside. The command engine sends single-cycle pulses for the enable and disable commands and a pulse when the internal write cycle ends.

Two valid/ready channels carry write requests into the unit. One carries a status byte and the other carries a target array address. A transfer takes place on a clock edge where valid and ready are both high. The unit either grants it, which starts a write cycle and raises busy, or refuses it without any state change. Both ready signals stay low while busy is high. When both channels are valid in the same cycle, the status channel wins and the array channel is held off. A sender must keep valid and its payload steady until ready is high.

A combinational query port reports whether a given address, and whether the status register, could be written now. This lets the command engine decide ahead of time whether to start a write. The status byte is always readable, including during a write cycle.

Top module: `eep_wrguard`

## Requirements
- R1: After reset the status byte reads 0x00 and both request channels are ready.
- R2: Status byte fields: bit 7 is the lock enable, bits 3:2 are the range bits (bit 3 high, bit 2 low), bit 1 is the write-enable latch, bit 0 is busy; bits 6:4 always read 0.
- R3: An enable pulse sets the latch and a disable pulse clears it, whatever the lock pin and lock enable are; disable wins if both arrive together.
- R4: With the latch clear, neither query output is high, and an accepted request of either kind changes nothing and does not raise busy.
- R5: Range bits 00 protect nothing, 01 protect the top quarter of the address space, 10 the top half, 11 everything; an address query is high only for an unprotected address while the latch is set.
- R6: The status query is low when the lock enable is 1 and the lock pin is low; with the lock enable at 0 the pin has no effect.
- R7: A granted status write loads only bits 7, 3 and 2 from the data byte and sets busy, both visible the cycle after the transfer.
- R8: A granted array write sets busy; an array write to a protected address is refused and leaves busy at 0 and the latch set.
- R9: A done pulse while busy clears busy and the latch in the next cycle.
- R10: Both ready outputs are low while busy; the array channel's ready is low whenever the status channel is valid.
- R11: A lock-pin fall after a status write has been granted does not alter the value written or stop the cycle from completing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| lock_pin_n | input | 1 | Hardware lock pin, active low |
| op_wren | input | 1 | Enable command completed (pulse) |
| op_wrdi | input | 1 | Disable command completed (pulse) |
| cyc_done | input | 1 | Internal write cycle finished (pulse) |
| sr_wr_valid | input | 1 | Status write request valid |
| sr_wr_data | input | 8 | Status byte to write |
| sr_wr_ready | output | 1 | Status channel can accept |
| arr_wr_valid | input | 1 | Array write request valid |
| arr_wr_addr | input | ADDR_W | Array page address |
| arr_wr_ready | output | 1 | Array channel can accept |
| q_addr | input | ADDR_W | Address to query |
| q_arr_ok | output | 1 | Query address is writable now |
| q_sr_ok | output | 1 | Status register is writable now |
| status_byte | output | 8 | Current status byte |

## Verification
The assertions assume that the command engine raises the done pulse only to end a cycle that this unit started. They also assume it never sends an enable and a disable pulse in the same cycle unless the disable-wins rule is being checked. The bench drives every pulse for one cycle, on the falling edge. It sends done only while busy reads 1, and it changes the lock pin only between transfers or inside a running cycle. Each assertion that depends on a pulse also excludes the other pulses in the same cycle, so that legal overlaps do not trip it.

// File: rtl/eep_wrguard_pkg.sv
package eep_wrguard_pkg;
  typedef enum logic [1:0] {
    RNG_NONE    = 2'b00,
    RNG_QUARTER = 2'b01,
    RNG_HALF    = 2'b10,
    RNG_ALL     = 2'b11
  } range_e;

  typedef struct packed {
    logic   lock_en;
    range_e range;
  } nv_bits_t;

  function automatic logic [7:0] pack_status(nv_bits_t nv, logic wel, logic busy);
    return {nv.lock_en, 3'b000, nv.range, wel, busy};
  endfunction
endpackage

// File: rtl/eep_region_guard.sv
module eep_region_guard
  import eep_wrguard_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  range_e            range,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  localparam int TOP = ADDR_W - 1;

  logic [ADDR_W-3:0] unused_low;
  assign unused_low = addr[ADDR_W-3:0];

  always_comb begin
    unique case (range)
      RNG_NONE:    locked = 1'b0;
      RNG_QUARTER: locked = addr[TOP] & addr[TOP-1];
      RNG_HALF:    locked = addr[TOP];
      default:     locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/eep_wel_latch.sv
module eep_wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic cycle_end_i,
  output logic wel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wel_o <= 1'b0;
    else if (clr_i)      wel_o <= 1'b0;
    else if (set_i)      wel_o <= 1'b1;
    else if (cycle_end_i) wel_o <= 1'b0;
  end
endmodule

// File: rtl/eep_sr_regs.sv
module eep_sr_regs
  import eep_wrguard_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  logic [7:0] data_i,
  input  logic     start_i,
  input  logic     done_i,
  output nv_bits_t nv_o,
  output logic     busy_o
);
  logic [2:0] unused_data;
  assign unused_data = {data_i[6:4]} ^ {1'b0, data_i[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_o <= '{lock_en: 1'b0, range: RNG_NONE};
    end else if (load_i) begin
      nv_o.lock_en <= data_i[7];
      nv_o.range   <= range_e'(data_i[3:2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_o <= 1'b0;
    else if (start_i) busy_o <= 1'b1;
    else if (done_i)  busy_o <= 1'b0;
  end
endmodule

// File: rtl/eep_wrguard.sv
module eep_wrguard
  import eep_wrguard_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_pin_n,
  input  logic              op_wren,
  input  logic              op_wrdi,
  input  logic              cyc_done,
  input  logic              sr_wr_valid,
  input  logic [7:0]        sr_wr_data,
  output logic              sr_wr_ready,
  input  logic              arr_wr_valid,
  input  logic [ADDR_W-1:0] arr_wr_addr,
  output logic              arr_wr_ready,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              q_arr_ok,
  output logic              q_sr_ok,
  output logic [7:0]        status_byte
);
  nv_bits_t nv;
  logic     wel, busy;
  logic     q_locked, req_locked;
  logic     sr_grant, arr_grant, cycle_end;

  eep_region_guard #(.ADDR_W(ADDR_W)) u_guard_q (
    .range(nv.range), .addr(q_addr), .locked(q_locked)
  );
  eep_region_guard #(.ADDR_W(ADDR_W)) u_guard_req (
    .range(nv.range), .addr(arr_wr_addr), .locked(req_locked)
  );

  assign sr_wr_ready  = ~busy;
  assign arr_wr_ready = ~busy & ~sr_wr_valid;

  assign q_sr_ok  = wel & ~(nv.lock_en & ~lock_pin_n);
  assign q_arr_ok = wel & ~q_locked;

  assign sr_grant  = sr_wr_valid & sr_wr_ready & q_sr_ok;
  assign arr_grant = arr_wr_valid & arr_wr_ready & wel & ~req_locked;
  assign cycle_end = cyc_done & busy;

  eep_wel_latch u_wel (
    .clk(clk), .rst_n(rst_n), .set_i(op_wren), .clr_i(op_wrdi),
    .cycle_end_i(cycle_end), .wel_o(wel)
  );

  eep_sr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .load_i(sr_grant), .data_i(sr_wr_data),
    .start_i(sr_grant | arr_grant), .done_i(cycle_end),
    .nv_o(nv), .busy_o(busy)
  );

  assign status_byte = pack_status(nv, wel, busy);
endmodule

// File: rtl/eep_wrguard_chk.sv
module eep_wrguard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lock_pin_n,
  input logic       op_wren,
  input logic       op_wrdi,
  input logic       cyc_done,
  input logic       sr_wr_valid,
  input logic       sr_wr_ready,
  input logic       arr_wr_ready,
  input logic       q_arr_ok,
  input logic       q_sr_ok,
  input logic [7:0] status_byte
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[6:4] == 3'b000);

  assert_wren_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wren && !op_wrdi) |=> status_byte[1]);

  assert_wrdi_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_wrdi |=> !status_byte[1]);

  assert_no_latch_no_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !status_byte[1] |-> (!q_arr_ok && !q_sr_ok));

  assert_no_latch_stays_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_byte[1] && !status_byte[0]) |=> !status_byte[0]);

  assert_all_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[3:2] == 2'b11) |-> !q_arr_ok);

  assert_pin_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[7] && !lock_pin_n) |-> !q_sr_ok);

  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[0] && cyc_done && !op_wren) |=> (!status_byte[0] && !status_byte[1]));

  assert_busy_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[0] |-> (!sr_wr_ready && !arr_wr_ready));

  assert_sr_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_valid |-> !arr_wr_ready);
endmodule

bind eep_wrguard eep_wrguard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .lock_pin_n(lock_pin_n), .op_wren(op_wren),
  .op_wrdi(op_wrdi), .cyc_done(cyc_done), .sr_wr_valid(sr_wr_valid),
  .sr_wr_ready(sr_wr_ready), .arr_wr_ready(arr_wr_ready), .q_arr_ok(q_arr_ok),
  .q_sr_ok(q_sr_ok), .status_byte(status_byte)
);

// File: tb/eep_wrguard_tb.sv
module eep_wrguard_tb_top;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lock_pin_n = 1'b1;
  logic          op_wren = 1'b0, op_wrdi = 1'b0, cyc_done = 1'b0;
  logic          sr_wr_valid = 1'b0;
  logic [7:0]    sr_wr_data = 8'h00;
  logic          sr_wr_ready;
  logic          arr_wr_valid = 1'b0;
  logic [AW-1:0] arr_wr_addr = '0;
  logic          arr_wr_ready;
  logic [AW-1:0] q_addr = '0;
  logic          q_arr_ok, q_sr_ok;
  logic [7:0]    status_byte;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  eep_wrguard #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lock_pin_n(lock_pin_n), .op_wren(op_wren),
    .op_wrdi(op_wrdi), .cyc_done(cyc_done), .sr_wr_valid(sr_wr_valid),
    .sr_wr_data(sr_wr_data), .sr_wr_ready(sr_wr_ready),
    .arr_wr_valid(arr_wr_valid), .arr_wr_addr(arr_wr_addr),
    .arr_wr_ready(arr_wr_ready), .q_addr(q_addr), .q_arr_ok(q_arr_ok),
    .q_sr_ok(q_sr_ok), .status_byte(status_byte)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_sr(input string req, input logic [7:0] exp);
    check(status_byte == exp, req, status_byte, exp);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_wren();
    op_wren = 1'b1; tick(); op_wren = 1'b0;
  endtask

  task automatic do_wrdi();
    op_wrdi = 1'b1; tick(); op_wrdi = 1'b0;
  endtask

  task automatic do_done();
    cyc_done = 1'b1; tick(); cyc_done = 1'b0;
  endtask

  task automatic sr_write(input logic [7:0] d);
    sr_wr_valid = 1'b1; sr_wr_data = d; tick(); sr_wr_valid = 1'b0;
  endtask

  task automatic arr_write(input logic [AW-1:0] a);
    arr_wr_valid = 1'b1; arr_wr_addr = a; tick(); arr_wr_valid = 1'b0;
  endtask

  task automatic set_status(input logic [7:0] d);
    do_wren(); sr_write(d); do_done();
  endtask

  task automatic query(input logic [AW-1:0] a, input bit exp, input string req);
    q_addr = a; #1;
    check(q_arr_ok == exp, req, q_arr_ok, exp);
  endtask

  task automatic t_reset();
    check_sr("R1 reset status", 8'h00);
    check(sr_wr_ready && arr_wr_ready, "R1 ready after reset", {sr_wr_ready, arr_wr_ready}, 3);
  endtask

  task automatic t_latch();
    do_wren();  check_sr("R3 enable sets latch", 8'h02);
    do_wrdi();  check_sr("R3 disable clears latch", 8'h00);
    lock_pin_n = 1'b0;
    do_wren();  check_sr("R3 enable with pin low", 8'h02);
    op_wren = 1'b1; op_wrdi = 1'b1; tick(); op_wren = 1'b0; op_wrdi = 1'b0;
    check_sr("R3 disable wins", 8'h00);
    lock_pin_n = 1'b1;
  endtask

  task automatic t_no_latch();
    q_addr = '0; #1;
    check(!q_sr_ok && !q_arr_ok, "R4 queries low without latch", {q_sr_ok, q_arr_ok}, 0);
    sr_write(8'h8C);      check_sr("R4 status write ignored", 8'h00);
    arr_write(13'h0010);  check_sr("R4 array write ignored", 8'h00);
  endtask

  task automatic t_status_write();
    do_wren();
    sr_write(8'hFC);
    check_sr("R7 only bits 7,3,2 load, busy set", 8'h8F);
    check(!sr_wr_ready && !arr_wr_ready, "R10 stalled while busy", {sr_wr_ready, arr_wr_ready}, 0);
    do_done();
    check_sr("R9 done clears busy and latch", 8'h8C);
    do_wren();
    query(13'h0000, 1'b0, "R5 range 11 locks address 0");
  endtask

  task automatic t_pin_lock();
    lock_pin_n = 1'b0; #1;
    check(!q_sr_ok, "R6 pin lock blocks status", q_sr_ok, 0);
    sr_write(8'h00);  check_sr("R6 locked write refused", 8'h8E);
    lock_pin_n = 1'b1;
    sr_write(8'h04);  check_sr("R7 status write with pin high", 8'h07);
    do_done();        check_sr("R9 cycle end", 8'h04);
    do_wren();
    lock_pin_n = 1'b0; #1;
    check(q_sr_ok, "R6 pin ignored when lock enable 0", q_sr_ok, 1);
    lock_pin_n = 1'b1;
  endtask

  task automatic t_ranges();
    query(13'h17FF, 1'b1, "R5 range 01 below quarter");
    query(13'h1800, 1'b0, "R5 range 01 top quarter");
    set_status(8'h08); do_wren();
    query(13'h0FFF, 1'b1, "R5 range 10 lower half");
    query(13'h1000, 1'b0, "R5 range 10 upper half");
  endtask

  task automatic t_array();
    arr_write(13'h1020);  check_sr("R8 protected page refused", 8'h0A);
    arr_write(13'h0040);  check_sr("R8 granted array write busy", 8'h0B);
    check(!arr_wr_ready, "R10 array stalled while busy", arr_wr_ready, 0);
    lock_pin_n = 1'b0; tick();
    do_done();            check_sr("R9 array cycle end", 8'h08);
    lock_pin_n = 1'b1;
    set_status(8'h00); do_wren();
    query(13'h1FFF, 1'b1, "R5 range 00 top address open");
  endtask

  task automatic t_pin_mid_cycle();
    set_status(8'h80);
    do_wren();
    sr_write(8'h88);   check_sr("R11 granted before pin drop", 8'h8B);
    lock_pin_n = 1'b0; tick();
    check_sr("R11 value held after pin drop", 8'h8B);
    do_done();         check_sr("R11 cycle completes", 8'h88);
    lock_pin_n = 1'b1;
  endtask

  task automatic t_priority();
    do_wren();
    sr_wr_valid = 1'b1; sr_wr_data = 8'h00; arr_wr_valid = 1'b1; arr_wr_addr = 13'h0000; #1;
    check(sr_wr_ready && !arr_wr_ready, "R10 status channel wins", {sr_wr_ready, arr_wr_ready}, 2);
    tick(); sr_wr_valid = 1'b0; arr_wr_valid = 1'b0;
    check_sr("R10 status write taken", 8'h03);
    do_done();   check_sr("R9 final idle", 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_no_latch();
    t_status_write();
    t_pin_lock();
    t_ranges();
    t_array();
    t_pin_mid_cycle();
    t_priority();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule